// File: doc/BRIEF.md
# Serial GPIO Chain Shift Controller

This block runs a serial chain of up to 32 external ports, each carrying the same number of bits (1 to 4), over four wires: a shift clock, a serial data output, a serial data input and a load strobe. A simple register port lets software choose the bits per port, the shift clock divider, which ports belong to the chain, and the level that each port bit drives. The same port also reads back the input levels captured from the chain.

One frame walks the ports in ascending order. Within each enabled port it sends bit 0 first. For every bit, the output level is placed on the data line and the input level is sampled while the shift clock is high. After the last port, the load strobe is raised for one bit period and the sampled levels are committed. Input levels are stored transposed: one word per bit index, holding one bit per port. Frames either run once per software start or repeat back to back when auto-repeat is set.

Top module: `sgc_top`

## Requirements
- R1: After reset: the config word reads 0, the divider reads 8 (100 MHz system clock over a 12.5 MHz bus), the port enable mask, every port word and every input word read 0, and ser_clk, ser_dout and ser_load are low.
- R2: Register map on `addr`. At 0x00 is config: [1:0] bits-per-port minus one, [2] auto-repeat, [3] start, which is write-only and reads 0. At 0x01 is the divider [11:0]. At 0x02 is the 32-bit port enable mask. At 0x10+b is the read-only input word for bit index b, and writes to it are ignored. At 0x20+p is the 12-bit source word of port p. Unused bits read 0.
- R3: Each frame produces one ser_clk pulse per bit of each enabled port, taking ports in ascending order and bits 0..W-1 within a port. At each rising ser_clk, ser_dout equals bit 3*b of port p's source word.
- R4: A port whose enable bit is 0 gets no ser_clk pulse, and its bits in every input word keep their previous value.
- R5: ser_din is sampled while ser_clk is high. Once the frame's load strobe ends, bit p of input word b holds the level sampled for port p, bit b, for every enabled port and every b < W. Input words with b >= W are unchanged.
- R6: With D = max(2, divider), each bit lasts D system cycles: ser_clk is low for floor(D/2) cycles and then high for D - floor(D/2) cycles. Consecutive bits of one port rise exactly D cycles apart.
- R7: After the last port, ser_load is high for exactly D cycles, once per frame, with ser_clk low throughout.
- R8: With auto-repeat clear, writing config with bit 3 set while idle runs exactly one frame, after which the chain stays idle. A start written while a frame is running is ignored.
- R9: While auto-repeat is set, frames run back to back. A frame's first ser_clk rise comes floor(D/2)+1 cycles after the previous frame's last ser_load cycle, when port 0 is enabled. Clearing the bit lets the current frame finish, and then the chain stays idle.
- R10: Divider values 0 and 1 behave as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for reads and writes |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| ser_clk | output | 1 | Chain shift clock |
| ser_dout | output | 1 | Chain serial data output |
| ser_din | input | 1 | Chain serial data input |
| ser_load | output | 1 | Chain load strobe, high for one bit period per frame |

## Verification
A register write takes effect at the clock edge that closes its cycle, and reads are combinational, so the bench reads values back a fraction of a cycle after driving the address. Serial results are tied to the chain's own events, not to fixed cycle counts. The bench samples on the falling system clock edge. There it records ser_dout at the first sample where ser_clk is seen high, and from the same sample it drives ser_din, which the design takes at the end of the high phase. High-phase lengths, rise-to-rise spacing and strobe length are counted against D. Input words are read only after ser_load has fallen, which is the first point at which R5 promises new contents, and the auto-repeat gap is measured from the last strobe sample to the next rise.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  typedef enum logic [1:0] {
    SGC_IDLE  = 2'd0,
    SGC_SHIFT = 2'd1,
    SGC_LOAD  = 2'd2
  } sgc_state_e;

  localparam int SGC_ADDR_W = 6;

  localparam logic [SGC_ADDR_W-1:0] SGC_A_CFG = 6'h00;
  localparam logic [SGC_ADDR_W-1:0] SGC_A_DIV = 6'h01;
  localparam logic [SGC_ADDR_W-1:0] SGC_A_PEN = 6'h02;
  localparam logic [SGC_ADDR_W-1:0] SGC_A_IN  = 6'h10;
  localparam logic [SGC_ADDR_W-1:0] SGC_A_OUT = 6'h20;

  localparam int SGC_CFG_AUTO  = 2;
  localparam int SGC_CFG_START = 3;

endpackage

// File: rtl/sgc_regs.sv
module sgc_regs
  import sgc_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIV_W   = 12,
  parameter int DIV_RST = 8,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int BIDX_W = (MAXBITS > 1) ? $clog2(MAXBITS) : 1,
  localparam int SRC_W  = 3 * MAXBITS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SGC_ADDR_W-1:0]           addr,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  output logic [BIDX_W-1:0]               width,
  output logic                            auto_rep,
  output logic                            start,
  output logic [DIV_W-1:0]                div_val,
  output logic [NPORTS-1:0]               port_en,
  input  logic [PIDX_W-1:0]               sel_port,
  input  logic [BIDX_W-1:0]               sel_bit,
  output logic                            out_bit,
  input  logic                            commit,
  input  logic [MAXBITS-1:0][NPORTS-1:0]  cap_data
);

  logic [BIDX_W-1:0]              width_q, width_d;
  logic                           auto_q, auto_d;
  logic [DIV_W-1:0]               div_q, div_d;
  logic [NPORTS-1:0]              pen_q, pen_d;
  logic [NPORTS-1:0][SRC_W-1:0]   src_q, src_d;
  logic [MAXBITS-1:0][NPORTS-1:0] in_q, in_d;

  logic [SGC_ADDR_W-1:0] out_off;
  logic                  hit_out;
  logic [SRC_W-1:0]      sel_word;

  assign out_off = addr - SGC_A_OUT;
  assign hit_out = (addr >= SGC_A_OUT) && (32'(out_off) < NPORTS);

  // next-state: software writes and frame commit
  always_comb begin
    width_d = width_q;
    auto_d  = auto_q;
    div_d   = div_q;
    pen_d   = pen_q;
    src_d   = src_q;
    in_d    = in_q;
    if (wr_en) begin
      if (addr == SGC_A_CFG) begin
        width_d = wdata[BIDX_W-1:0];
        auto_d  = wdata[SGC_CFG_AUTO];
      end
      if (addr == SGC_A_DIV) div_d = wdata[DIV_W-1:0];
      if (addr == SGC_A_PEN) pen_d = wdata[NPORTS-1:0];
      for (int p = 0; p < NPORTS; p++) begin
        if (hit_out && (32'(out_off) == p)) src_d[p] = wdata[SRC_W-1:0];
      end
    end
    if (commit) begin
      for (int b = 0; b < MAXBITS; b++) begin
        if (32'(width_q) >= b) in_d[b] = (cap_data[b] & pen_q) | (in_q[b] & ~pen_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      auto_q  <= 1'b0;
      div_q   <= DIV_W'(DIV_RST);
      pen_q   <= '0;
      src_q   <= '0;
      in_q    <= '0;
    end else begin
      width_q <= width_d;
      auto_q  <= auto_d;
      div_q   <= div_d;
      pen_q   <= pen_d;
      src_q   <= src_d;
      in_q    <= in_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == SGC_A_CFG) begin
      rdata[BIDX_W-1:0]   = width_q;
      rdata[SGC_CFG_AUTO] = auto_q;
    end
    if (addr == SGC_A_DIV) rdata[DIV_W-1:0] = div_q;
    if (addr == SGC_A_PEN) rdata[NPORTS-1:0] = pen_q;
    for (int b = 0; b < MAXBITS; b++) begin
      if (32'(addr) == 32'(SGC_A_IN) + b) rdata[NPORTS-1:0] = in_q[b];
    end
    if (hit_out) rdata[SRC_W-1:0] = src_q[out_off[PIDX_W-1:0]];
  end

  // output level: bit 0 of the 3-bit source group of the selected bit
  assign sel_word = src_q[sel_port];
  always_comb begin
    out_bit = 1'b0;
    for (int b = 0; b < MAXBITS; b++) begin
      if (32'(sel_bit) == b) out_bit = sel_word[3*b];
    end
  end

  assign start    = wr_en && (addr == SGC_A_CFG) && wdata[SGC_CFG_START];
  assign width    = width_q;
  assign auto_rep = auto_q;
  assign div_val  = div_q;
  assign port_en  = pen_q;

  // R2, R5: input words move only on a frame commit
  a_r5_in_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(in_q));

endmodule

// File: rtl/sgc_shifter.sv
module sgc_shifter
  import sgc_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIV_W   = 12,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int BIDX_W = (MAXBITS > 1) ? $clog2(MAXBITS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic                            auto_rep,
  input  logic [BIDX_W-1:0]               width,
  input  logic [DIV_W-1:0]                div_val,
  input  logic [NPORTS-1:0]               port_en,
  input  logic                            sdi,
  output logic [PIDX_W-1:0]               sel_port,
  output logic [BIDX_W-1:0]               sel_bit,
  input  logic                            out_bit,
  output logic                            sclk,
  output logic                            sdo,
  output logic                            sld,
  output logic                            commit,
  output logic [MAXBITS-1:0][NPORTS-1:0]  cap_data
);

  sgc_state_e state_q, state_d;
  logic [DIV_W-1:0]               cnt_q, cnt_d;
  logic [PIDX_W-1:0]              port_q, port_d;
  logic [BIDX_W-1:0]              bit_q, bit_d;
  logic [MAXBITS-1:0][NPORTS-1:0] cap_q, cap_d;
  logic [DIV_W-1:0]               eff_div, half_div, last_cnt;
  logic                           port_on, port_on_d;
  logic                           sclk_q, sdo_q, sld_q;

  assign eff_div  = (div_val < DIV_W'(2)) ? DIV_W'(2) : div_val;
  assign half_div = eff_div >> 1;
  assign last_cnt = eff_div - DIV_W'(1);
  assign port_on  = port_en[port_q];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    port_d  = port_q;
    bit_d   = bit_q;
    cap_d   = cap_q;
    commit  = 1'b0;
    case (state_q)
      SGC_IDLE: begin
        if (start || auto_rep) begin
          state_d = SGC_SHIFT;
          cnt_d   = '0;
          port_d  = '0;
          bit_d   = '0;
        end
      end
      SGC_SHIFT: begin
        if (port_on && (cnt_q != last_cnt)) begin
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = '0;
          if (port_on) cap_d[bit_q][port_q] = sdi;
          if (port_on && (bit_q != width)) begin
            bit_d = bit_q + 1'b1;
          end else begin
            bit_d = '0;
            if (port_q == PIDX_W'(NPORTS - 1)) state_d = SGC_LOAD;
            else                               port_d  = port_q + 1'b1;
          end
        end
      end
      SGC_LOAD: begin
        if (cnt_q != last_cnt) begin
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d  = '0;
          commit = 1'b1;
          port_d = '0;
          bit_d  = '0;
          state_d = auto_rep ? SGC_SHIFT : SGC_IDLE;
        end
      end
      default: state_d = SGC_IDLE;
    endcase
  end

  // outputs are registered from the next state, so they line up with it
  assign sel_port  = port_d;
  assign sel_bit   = bit_d;
  assign port_on_d = port_en[port_d];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SGC_IDLE;
      cnt_q   <= '0;
      port_q  <= '0;
      bit_q   <= '0;
      cap_q   <= '0;
      sclk_q  <= 1'b0;
      sdo_q   <= 1'b0;
      sld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      port_q  <= port_d;
      bit_q   <= bit_d;
      cap_q   <= cap_d;
      sclk_q  <= (state_d == SGC_SHIFT) && port_on_d && (cnt_d >= half_div);
      sdo_q   <= (state_d == SGC_SHIFT) && port_on_d && out_bit;
      sld_q   <= (state_d == SGC_LOAD);
    end
  end

  assign sclk     = sclk_q;
  assign sdo      = sdo_q;
  assign sld      = sld_q;
  assign cap_data = cap_q;

  a_r7_strobe_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    sld_q |-> !sclk_q);
  a_r4_clock_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> port_en[port_q]);
  a_r3_bit_within_width: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SGC_SHIFT) |-> (bit_q <= width));
  a_r6_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> (cnt_q == half_div));
  a_r8_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SGC_IDLE) && start) |=> (state_q == SGC_SHIFT));
  a_r9_repeat_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && auto_rep) |=> (state_q == SGC_SHIFT) && !sld_q);

endmodule

// File: rtl/sgc_top.sv
module sgc_top
  import sgc_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIV_W   = 12,
  parameter int SYS_HZ  = 100_000_000,
  parameter int BUS_HZ  = 12_500_000,
  localparam int PIDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int BIDX_W  = (MAXBITS > 1) ? $clog2(MAXBITS) : 1,
  localparam int DIV_RAW = SYS_HZ / BUS_HZ,
  localparam int DIV_RST = (DIV_RAW < 2) ? 2 : DIV_RAW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SGC_ADDR_W-1:0] addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  ser_clk,
  output logic                  ser_dout,
  input  logic                  ser_din,
  output logic                  ser_load
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [BIDX_W-1:0]              width;
  logic                           auto_rep, start, out_bit, commit;
  logic [DIV_W-1:0]               div_val;
  logic [NPORTS-1:0]              port_en;
  logic [PIDX_W-1:0]              sel_port;
  logic [BIDX_W-1:0]              sel_bit;
  logic [MAXBITS-1:0][NPORTS-1:0] cap_data;

  sgc_regs #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .DIV_W(DIV_W), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .width(width), .auto_rep(auto_rep), .start(start),
    .div_val(div_val), .port_en(port_en), .sel_port(sel_port), .sel_bit(sel_bit),
    .out_bit(out_bit), .commit(commit), .cap_data(cap_data)
  );

  sgc_shifter #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .DIV_W(DIV_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_sync), .start(start), .auto_rep(auto_rep),
    .width(width), .div_val(div_val), .port_en(port_en), .sdi(ser_din),
    .sel_port(sel_port), .sel_bit(sel_bit), .out_bit(out_bit),
    .sclk(ser_clk), .sdo(ser_dout), .sld(ser_load), .commit(commit),
    .cap_data(cap_data)
  );

endmodule

// File: tb/sim_sgc_top.sv
module sim_sgc_top;
  localparam int NP = 32;
  localparam int MB = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, wr_en, ser_din;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        ser_clk, ser_dout, ser_load;

  sgc_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din),
    .ser_load(ser_load)
  );

  int n_chk = 0;
  int n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [11:0] out_w [NP];
  logic [31:0] in_pat [MB];
  logic [31:0] in_model [MB];
  logic [31:0] cur_en;
  int cur_w, cur_d;
  int seq_p [128];
  int seq_b [128];
  int n_exp;
  int r_rise, r_sdo_bad, r_pulses, r_sld_len, r_hi_bad, r_per_bad;
  longint r_first_rise, r_last_sld;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic int eff(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic [31:0] exp_word(input int b);
    if (b < cur_w) return (in_pat[b] & cur_en) | (in_model[b] & ~cur_en);
    return in_model[b];
  endfunction

  task automatic build_seq();
    n_exp = 0;
    for (int p = 0; p < NP; p++)
      if (cur_en[p])
        for (int b = 0; b < cur_w; b++) begin
          seq_p[n_exp] = p; seq_b[n_exp] = b; n_exp++;
        end
  endtask

  task automatic setup(input logic [31:0] en, input int w, input int d);
    cur_en = en; cur_w = w; cur_d = eff(d);
    wr(6'h02, en);
    wr(6'h01, 32'(d));
    wr(6'h00, 32'(w - 1));
    for (int p = 0; p < NP; p++) wr(6'h20 + 6'(p), 32'(out_w[p]));
    build_seq();
  endtask

  // mode 0: observe; 1: clear auto-repeat at first rise; 2: write start at first rise
  task automatic run_frame(input int mode);
    bit prev_s, prev_l;
    int hi, k, guard, stage;
    longint last_rise;
    prev_s = 0; prev_l = 0; hi = 0; k = 0; guard = 0; stage = 0; last_rise = 0;
    r_sdo_bad = 0; r_pulses = 0; r_sld_len = 0; r_hi_bad = 0; r_per_bad = 0;
    r_first_rise = -1; r_last_sld = -1;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        chk(1'b0, "R7 frame end timeout", guard, 0);
        break;
      end
      if (stage == 1) begin wr_en = 1'b0; stage = 2; end
      if (ser_clk && !prev_s) begin
        if (k < n_exp) begin
          ser_din = in_pat[seq_b[k]][seq_p[k]];
          if (ser_dout !== out_w[seq_p[k]][3*seq_b[k]]) r_sdo_bad++;
          if (seq_b[k] > 0 && (cyc - last_rise) != cur_d) r_per_bad++;
        end
        if (k == 0) r_first_rise = cyc;
        last_rise = cyc;
        k++;
        if (mode != 0 && stage == 0) begin
          wr_en = 1'b1; addr = 6'h00;
          wdata = 32'(cur_w - 1) | ((mode == 2) ? 32'h8 : 32'h0);
          stage = 1;
        end
      end
      if (ser_clk) hi++;
      if (!ser_clk && prev_s) begin
        if (hi != cur_d - cur_d / 2) r_hi_bad++;
        hi = 0;
      end
      if (ser_load) begin
        r_sld_len++;
        if (ser_clk) r_hi_bad++;
      end
      if (ser_load && !prev_l) r_pulses++;
      if (!ser_load && prev_l) begin
        r_last_sld = cyc - 1;
        break;
      end
      prev_s = ser_clk; prev_l = ser_load;
    end
    r_rise = k;
  endtask

  task automatic seq_checks(input string tag);
    chk(r_rise == n_exp, {"R3 pulse count ", tag}, r_rise, n_exp);
    chk(r_sdo_bad == 0, {"R3 dout level ", tag}, r_sdo_bad, 0);
    chk(r_hi_bad == 0 && r_per_bad == 0, {"R6 clock shape ", tag}, r_hi_bad + r_per_bad, 0);
    chk(r_pulses == 1 && r_sld_len == cur_d, {"R7 strobe ", tag}, r_sld_len, cur_d);
  endtask

  task automatic word_checks(input string tag);
    logic [31:0] got, e;
    for (int b = 0; b < MB; b++) begin
      e = exp_word(b);
      rd(6'h10 + 6'(b), got);
      chk(got == e, {"R5 R4 input word ", tag}, got, e);
      in_model[b] = e;
    end
  endtask

  task automatic idle_check(input int n, input string req);
    int act;
    act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ser_clk || ser_load) act++;
    end
    chk(act == 0, req, act, 0);
  endtask

  task automatic randomize_data();
    for (int p = 0; p < NP; p++) out_w[p] = 12'($urandom);
    for (int b = 0; b < MB; b++) in_pat[b] = $urandom;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, r;
    longint prev_end;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; ser_din = 1'b0;
    for (int b = 0; b < MB; b++) in_model[b] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!ser_clk && !ser_load && !ser_dout, "R1 serial idle", {ser_clk, ser_load, ser_dout}, 0);
    rd(6'h00, r); chk(r == 0, "R1 config", r, 0);
    rd(6'h01, r); chk(r == 8, "R1 divider", r, 8);
    rd(6'h02, r); chk(r == 0, "R1 enable", r, 0);
    rd(6'h20, r); chk(r == 0, "R1 port word 0", r, 0);
    rd(6'h3F, r); chk(r == 0, "R1 port word 31", r, 0);
    for (int b = 0; b < MB; b++) begin
      rd(6'h10 + 6'(b), r); chk(r == 0, "R1 input word", r, 0);
    end

    // R2 register readback
    v = $urandom; wr(6'h01, v); rd(6'h01, r); chk(r == (v & 32'hFFF), "R2 divider", r, v & 32'hFFF);
    v = $urandom; wr(6'h02, v); rd(6'h02, r); chk(r == v, "R2 enable", r, v);
    v = $urandom; wr(6'h27, v); rd(6'h27, r); chk(r == (v & 32'hFFF), "R2 port word", r, v & 32'hFFF);
    wr(6'h00, 32'h3); rd(6'h00, r); chk(r == 3, "R2 config", r, 3);
    wr(6'h11, 32'hFFFF_FFFF); rd(6'h11, r); chk(r == 0, "R2 input word write ignored", r, 0);
    rd(6'h05, r); chk(r == 0, "R2 unused address", r, 0);

    // directed: all ports, 4 bits, fastest clock
    randomize_data();
    setup(32'hFFFF_FFFF, 4, 2);
    wr(6'h00, 32'h3 | 32'h8);
    run_frame(0); seq_checks("full chain"); word_checks("full chain");
    rd(6'h00, r); chk(r == 3, "R2 start reads zero", r, 3);
    idle_check(40, "R8 single shot stays idle");

    // R4: empty chain
    randomize_data();
    setup(32'h0, 2, 3);
    wr(6'h00, 32'h1 | 32'h8);
    run_frame(0); seq_checks("R4 no ports"); word_checks("R4 no ports");

    // R10: divider 0 and 1
    for (int d = 0; d < 2; d++) begin
      randomize_data();
      setup(32'h0000_00F0, 2, d);
      wr(6'h00, 32'h1 | 32'h8);
      run_frame(0);
      chk(r_hi_bad == 0 && r_per_bad == 0 && r_sld_len == 2, "R10 divider clamp", r_sld_len, 2);
      word_checks("R10");
    end

    // random frames
    for (int it = 0; it < 8; it++) begin
      randomize_data();
      v = $urandom & $urandom;
      if (it == 0) v = 32'h8000_0001;
      setup(v, 1 + int'($urandom % 4), 2 + int'($urandom % 7));
      wr(6'h00, 32'(cur_w - 1) | 32'h8);
      run_frame(0); seq_checks("random"); word_checks("random");
    end

    // R8: start during a frame is ignored
    randomize_data();
    setup(32'h0F0F_0F0F, 3, 3);
    wr(6'h00, 32'h2 | 32'h8);
    run_frame(2); seq_checks("R8 busy start"); word_checks("R8 busy start");
    idle_check(60, "R8 busy start ignored");

    // R9: auto-repeat
    randomize_data();
    setup(32'hFFFF_FFFF, 1, 4);
    wr(6'h00, 32'h0 | 32'h4);
    run_frame(0); seq_checks("R9 frame 1");
    prev_end = r_last_sld;
    run_frame(0); seq_checks("R9 frame 2");
    chk(r_first_rise - prev_end == 3, "R9 back-to-back gap", r_first_rise - prev_end, 3);
    run_frame(1); seq_checks("R9 frame 3");
    idle_check(60, "R9 stops after clear");
    word_checks("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule